// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the serial control port of a clock generator. It listens to an SMBus-style two-wire bus (SCL, SDA) as a slave only, and it holds three configuration bytes that steer the generator's outputs. A master writes the bytes with a block-write transaction, and it reads them back with a block read. The stored bits leave the block as parallel control outputs. Some read-back bits are not stored: they show the live level of the two frequency-select pins, and one shows the effective halt signal.

Both bus lines pass through a synchronizer clocked by the system clock. An edge detector then finds SCL rising and falling edges and START and STOP conditions. A state machine with five states walks through each transaction. ST_IDLE waits for START. ST_RX_BYTE shifts in eight bits on SCL rising edges. ST_ACK_OUT drives the acknowledge slot low. ST_TX_BYTE presents read data, MSB first, changing it on SCL falling edges. ST_ACK_IN samples the master's acknowledge.

The transitions are:
- START in any state leads to ST_RX_BYTE in the address phase.
- STOP in any state leads to ST_IDLE.
- ST_RX_BYTE goes to ST_ACK_OUT after eight bits. If the byte is an address the block does not own, it goes to ST_IDLE instead.
- ST_ACK_OUT goes to ST_RX_BYTE in write mode, or to ST_TX_BYTE in read mode.
- ST_TX_BYTE goes to ST_ACK_IN after eight bits.
- ST_ACK_IN goes back to ST_TX_BYTE on ACK, or to ST_IDLE on NACK.

A phase register tracks which byte of a write is being received: address, command, count or data.

Top module: `twc_cfg_slave`

## Requirements
- R1: The block acknowledges the address byte 0xD2 (write) and 0xD3 (read). It does not acknowledge any other address byte, and such a transaction changes no output.
- R2: After a write address, the block acknowledges a command byte and then a byte-count byte. The values of both bytes have no effect on which register is written or how many are written.
- R3: Data bytes after the count go to register bytes 0, 1 and 2 in that order, and each one is acknowledged. A fourth or later data byte is acknowledged and discarded.
- R4: After reset, the outputs are as follows:
  - spread, power-down three-state, alternate frequency, halt-three-state and both free-run outputs are 0;
  - both output enables are 1;
  - the auxiliary byte is 0x00;
  - byte 1 reads as 0x87.
- R5: Byte 0 has this layout:
  - bit 7 is spread enable, bit 6 is power-down three-state, bit 5 is alternate frequency select;
  - bit 3 reads the sel_hi pin and bit 2 reads the sel_lo pin;
  - bits 1:0 read 0;
  - writes to bits 3:0 are discarded.
- R6: Byte 0 bit 4 is a stored halt bit with reset value 1. The halt_eff_n output, and bit 4 as read back, both equal the stored bit AND the active-low halt pin.
- R7: Byte 1 has this layout:
  - bit 6 is halt three-state, bit 5 is output 2 free-run, bit 4 is output 1 free-run;
  - bit 2 is output 2 enable, bit 1 is output 1 enable;
  - bits 7 and 0 always read 1 and bit 3 always reads 0, and writes to those bits are discarded.
- R8: All eight bits of byte 2 are writable and drive the aux_cfg output.
- R9: A read returns byte 0, then byte 1, then byte 2, each MSB first. Any further byte reads as 0xFF. After the master NACKs a byte, the block no longer drives SDA.
- R10: A START in any state restarts address reception. A STOP in any state returns the block to idle. A data byte cut short by START or STOP changes no register.
- R11: SDA is driven low only in an acknowledge slot or for a 0 bit of read data, and the drive changes only while SCL is low.
- R12: Register contents persist across transactions. A write that carries fewer than three data bytes leaves the later bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low_o | output | 1 | Enable for the open-drain pull-down on SDA |
| sel_hi_i | input | 1 | Frequency-select pin, reflected in byte 0 bit 3 |
| sel_lo_i | input | 1 | Frequency-select pin, reflected in byte 0 bit 2 |
| halt_pin_n_i | input | 1 | External active-low halt pin |
| spread_en_o | output | 1 | Spread enable |
| pd_tristate_o | output | 1 | Power-down output mode select |
| alt_freq_o | output | 1 | Alternate frequency select for the shared output |
| halt_eff_n_o | output | 1 | Effective active-low halt (stored bit AND pin) |
| stop_tristate_o | output | 1 | Output behaviour during a stop |
| out2_free_o | output | 1 | Output 2 keeps running during a stop |
| out1_free_o | output | 1 | Output 1 keeps running during a stop |
| out2_en_o | output | 1 | Output 2 enable |
| out1_en_o | output | 1 | Output 1 enable |
| aux_cfg_o | output | 8 | Auxiliary configuration byte |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a START or STOP. They also assume that every bus level is held for several system clocks, so the synchronizer sees each edge on its own. Under those conditions a drive change while SCL is high would be a real fault. The bench's bit-banged master holds each SCL phase for eight system clocks. It always sets SDA one full phase before raising SCL, and it produces START and STOP only with SCL held high.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int unsigned TWC_NREG  = 3;
    localparam int unsigned TWC_IDX_W = $clog2(TWC_NREG + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_BYTE,
        ST_ACK_OUT,
        ST_TX_BYTE,
        ST_ACK_IN
    } twc_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } twc_phase_e;

    // Writable-bit masks and power-up values per register byte.
    function automatic logic [7:0] reg_mask(int unsigned idx);
        case (idx)
            0:       return 8'hF0;
            1:       return 8'h76;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] reg_rst(int unsigned idx);
        case (idx)
            0:       return 8'h10;
            1:       return 8'h87;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/twc_line_sync.sv
module twc_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_chain;
    logic [STAGES:0] sda_chain;
    logic            scl_d;
    logic            sda_d;

    assign scl_chain[0] = scl_i;
    assign sda_chain[0] = sda_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_chain[g+1] <= 1'b1;
                sda_chain[g+1] <= 1'b1;
            end else begin
                scl_chain[g+1] <= scl_chain[g];
                sda_chain[g+1] <= sda_chain[g];
            end
        end
    end

    assign scl_s = scl_chain[STAGES];
    assign sda_s = sda_chain[STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twc_reg_bank.sv
module twc_reg_bank
    import twc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TWC_IDX_W-1:0] wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [TWC_IDX_W-1:0] rd_idx,
    output logic [7:0]           rd_data,
    input  logic                 sel_hi,
    input  logic                 sel_lo,
    input  logic                 halt_pin_n,
    output logic                 spread_en,
    output logic                 pd_tristate,
    output logic                 alt_freq,
    output logic                 halt_eff_n,
    output logic                 stop_tristate,
    output logic                 out2_free,
    output logic                 out1_free,
    output logic                 out2_en,
    output logic                 out1_en,
    output logic [7:0]           aux_cfg
);
    logic [7:0] regs [TWC_NREG];

    for (genvar g = 0; g < TWC_NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= reg_rst(g);
            end else if (wr_en && wr_idx == TWC_IDX_W'(g)) begin
                regs[g] <= (wr_data & reg_mask(g)) | (regs[g] & ~reg_mask(g));
            end
        end
    end

    assign halt_eff_n    = regs[0][4] & halt_pin_n;
    assign spread_en     = regs[0][7];
    assign pd_tristate   = regs[0][6];
    assign alt_freq      = regs[0][5];
    assign stop_tristate = regs[1][6];
    assign out2_free     = regs[1][5];
    assign out1_free     = regs[1][4];
    assign out2_en       = regs[1][2];
    assign out1_en       = regs[1][1];
    assign aux_cfg       = regs[2];

    always_comb begin
        case (rd_idx)
            TWC_IDX_W'(0): rd_data = (regs[0] & 8'hE3) | {3'b000, halt_eff_n, sel_hi, sel_lo, 2'b00};
            TWC_IDX_W'(1): rd_data = regs[1];
            TWC_IDX_W'(2): rd_data = regs[2];
            default:       rd_data = 8'hFF;
        endcase
    end

    // R12
    hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2])));

    // R6
    halt_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_pin_n |-> !halt_eff_n);
endmodule

// File: rtl/twc_cfg_slave.sv
module twc_cfg_slave
    import twc_pkg::*;
#(
    parameter logic [7:0]  WR_ADDR     = 8'hD2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low_o,
    input  logic       sel_hi_i,
    input  logic       sel_lo_i,
    input  logic       halt_pin_n_i,
    output logic       spread_en_o,
    output logic       pd_tristate_o,
    output logic       alt_freq_o,
    output logic       halt_eff_n_o,
    output logic       stop_tristate_o,
    output logic       out2_free_o,
    output logic       out1_free_o,
    output logic       out2_en_o,
    output logic       out1_en_o,
    output logic [7:0] aux_cfg_o
);
    localparam logic [7:0]           RD_ADDR = WR_ADDR | 8'h01;
    localparam logic [TWC_IDX_W-1:0] IDX_END = TWC_IDX_W'(TWC_NREG);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twc_state_e           state;
    twc_phase_e           phase;
    logic [2:0]           bitcnt;
    logic [7:0]           shreg;
    logic [7:0]           txbyte;
    logic                 byte_done;
    logic                 rd_mode;
    logic                 nack_seen;
    logic [TWC_IDX_W-1:0] idx;
    logic                 ack_ok;
    logic                 wr_en;
    logic [7:0]           rd_data;

    twc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twc_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_data(shreg),
        .rd_idx(idx), .rd_data(rd_data),
        .sel_hi(sel_hi_i), .sel_lo(sel_lo_i), .halt_pin_n(halt_pin_n_i),
        .spread_en(spread_en_o), .pd_tristate(pd_tristate_o), .alt_freq(alt_freq_o),
        .halt_eff_n(halt_eff_n_o), .stop_tristate(stop_tristate_o),
        .out2_free(out2_free_o), .out1_free(out1_free_o),
        .out2_en(out2_en_o), .out1_en(out1_en_o), .aux_cfg(aux_cfg_o)
    );

    assign ack_ok = (phase != PH_ADDR) || (shreg == WR_ADDR) || (shreg == RD_ADDR);

    // State register and transaction bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            txbyte    <= 8'hFF;
            byte_done <= 1'b0;
            rd_mode   <= 1'b0;
            nack_seen <= 1'b0;
            idx       <= '0;
        end else if (start_det) begin
            state     <= ST_RX_BYTE;
            phase     <= PH_ADDR;
            bitcnt    <= '0;
            byte_done <= 1'b0;
            rd_mode   <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RX_BYTE: begin
                    if (scl_rise) begin
                        shreg     <= {shreg[6:0], sda_s};
                        bitcnt    <= bitcnt + 3'd1;
                        byte_done <= (bitcnt == 3'd7);
                    end else if (scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        state     <= ack_ok ? ST_ACK_OUT : ST_IDLE;
                        unique case (phase)
                            PH_ADDR: begin
                                rd_mode <= shreg[0];
                                phase   <= PH_CMD;
                                idx     <= '0;
                            end
                            PH_CMD:   phase <= PH_COUNT;
                            PH_COUNT: phase <= PH_DATA;
                            PH_DATA:  if (idx != IDX_END) idx <= idx + 1'b1;
                        endcase
                    end
                end
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            state  <= ST_TX_BYTE;
                            txbyte <= rd_data;
                        end else begin
                            state <= ST_RX_BYTE;
                        end
                    end
                end
                ST_TX_BYTE: begin
                    if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            state <= ST_ACK_IN;
                            if (idx != IDX_END) idx <= idx + 1'b1;
                        end else begin
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                end
                ST_ACK_IN: begin
                    if (scl_rise) begin
                        nack_seen <= sda_s;
                    end else if (scl_fall) begin
                        if (nack_seen) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_TX_BYTE;
                            bitcnt <= '0;
                            txbyte <= rd_data;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs derived from the state.
    always_comb begin
        wr_en = (state == ST_RX_BYTE) && scl_fall && byte_done && (phase == PH_DATA)
                && (idx != IDX_END) && !start_det && !stop_det;
        sda_drive_low_o = (state == ST_ACK_OUT)
                       || ((state == ST_TX_BYTE) && !txbyte[3'd7 - bitcnt]);
    end

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));

    // R11
    drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_drive_low_o));

    // R11
    drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low_o |-> (state == ST_ACK_OUT || state == ST_TX_BYTE));
endmodule

// File: tb/twc_cfg_slave_tb.sv
module twc_cfg_slave_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sel_hi = 1'b0, sel_lo = 1'b0, halt_n = 1'b1;
    logic sda_drive_low;
    logic spread_en, pd_tristate, alt_freq, halt_eff_n, stop_tristate;
    logic out2_free, out1_free, out2_en, out1_en;
    logic [7:0] aux_cfg;
    logic sda_bus;

    int total = 0;
    int bad = 0;
    int drive_viol = 0;
    bit done = 1'b0;

    // Bench model of the writable bits.
    logic [7:0] m0 = 8'h10, m1 = 8'h87, m2 = 8'h00;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    twc_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low_o(sda_drive_low),
        .sel_hi_i(sel_hi), .sel_lo_i(sel_lo), .halt_pin_n_i(halt_n),
        .spread_en_o(spread_en), .pd_tristate_o(pd_tristate), .alt_freq_o(alt_freq),
        .halt_eff_n_o(halt_eff_n), .stop_tristate_o(stop_tristate),
        .out2_free_o(out2_free), .out1_free_o(out1_free),
        .out2_en_o(out2_en), .out1_en_o(out1_en), .aux_cfg_o(aux_cfg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] view0();
        return {m0[7:5], m0[4] & halt_n, sel_hi, sel_lo, 2'b00};
    endfunction

    function automatic logic [9:0] outs_act();
        return {spread_en, pd_tristate, alt_freq, halt_eff_n, stop_tristate,
                out2_free, out1_free, out2_en, out1_en, 1'b0};
    endfunction

    function automatic logic [9:0] outs_exp();
        return {m0[7:5], m0[4] & halt_n, m1[6:4], m1[2:1], 1'b0};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        if (sda_drive_low) drive_viol++;
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_bus;
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_bus};
            scl_m = 1'b0; tick(Q);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input logic [7:0] d3, output int acks);
        bit a;
        logic [7:0] d [4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        acks = 0;
        bus_start();
        send_byte(8'hD2, a); acks += int'(a);
        send_byte(cmd, a);   acks += int'(a);
        send_byte(cnt, a);   acks += int'(a);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a); acks += int'(a);
        end
        bus_stop();
        if (n > 0) m0 = (d0 & 8'hF0) | (m0 & 8'h0F);
        if (n > 1) m1 = (d1 & 8'h76) | (m1 & 8'h89);
        if (n > 2) m2 = d2;
    endtask

    task automatic do_read(output bit aok, output logic [7:0] r0, output logic [7:0] r1,
                           output logic [7:0] r2, output logic [7:0] r3);
        bus_start();
        send_byte(8'hD3, aok);
        read_byte(1'b0, r0);
        read_byte(1'b0, r1);
        read_byte(1'b0, r2);
        read_byte(1'b1, r3);
        bus_stop();
    endtask

    task automatic check_all(input string req);
        bit aok;
        logic [7:0] r0, r1, r2, r3;
        check({req, " outputs"}, {6'b0, outs_act()}, {6'b0, outs_exp()});
        check({req, " aux"}, {8'b0, aux_cfg}, {8'b0, m2});
        do_read(aok, r0, r1, r2, r3);
        check("R1 read address ack", {15'b0, aok}, 16'd1);
        check({req, " R9 byte0"}, {8'b0, r0}, {8'b0, view0()});
        check({req, " R9 byte1"}, {8'b0, r1}, {8'b0, m1});
        check({req, " R9 byte2"}, {8'b0, r2}, {8'b0, m2});
        check("R9 byte beyond 2", {8'b0, r3}, 16'h00FF);
    endtask

    initial begin
        int acks;
        bit a;
        logic [7:0] r0, r1, r2, r3;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R4 reset state
        check("R4 reset outputs", {6'b0, outs_act()}, {6'b0, 10'b0001000110});
        check("R4 reset aux", {8'b0, aux_cfg}, 16'h0000);
        check("R4 sda idle", {15'b0, sda_drive_low}, 16'd0);
        check_all("R4");

        // R5 R6 sweep pin levels on byte 0
        for (int p = 0; p < 8; p++) begin
            {sel_hi, sel_lo, halt_n} = 3'(p);
            tick(4);
            check("R6 halt_eff_n", {15'b0, halt_eff_n}, {15'b0, halt_n});
            do_read(a, r0, r1, r2, r3);
            check("R5 R6 byte0 pins", {8'b0, r0}, {8'b0, view0()});
        end
        halt_n = 1'b1;

        // R1 address sweep: only 0xD2 acknowledged among these
        for (int k = 0; k < 32; k++) begin
            logic [7:0] ad;
            ad = {k[4:0], 3'b010};
            bus_start();
            send_byte(ad, a);
            if (!a || ad != 8'hD2) begin
                for (int i = 0; i < 3; i++) send_byte(8'hFF, a);
            end
            bus_stop();
            check("R1 address ack", {15'b0, a}, {15'b0, ad == 8'hD2});
        end
        check("R1 no effect outputs", {6'b0, outs_act()}, {6'b0, outs_exp()});
        check("R1 no effect aux", {8'b0, aux_cfg}, {8'b0, m2});

        // R2 R3 R5 R7 R8 write patterns, extra byte discarded
        do_write(8'h00, 8'h03, 4, 8'hFF, 8'hFF, 8'hFF, 8'h11, acks);
        check("R3 R2 acks", 16'(acks), 16'd7);
        check_all("R5 R7 R8 ones");
        do_write(8'h5A, 8'h00, 4, 8'h00, 8'h00, 8'h00, 8'hEE, acks);
        check("R3 R2 acks count0", 16'(acks), 16'd7);
        check_all("R5 R7 R8 zeros");
        do_write(8'hC3, 8'h07, 3, 8'hA5, 8'h5A, 8'h3C, 8'h00, acks);
        check("R3 acks", 16'(acks), 16'd6);
        sel_hi = 1'b1; halt_n = 1'b0;
        tick(4);
        check_all("R5 R6 R7 mixed");
        halt_n = 1'b1;
        do_write(8'hFF, 8'h01, 3, 8'h5F, 8'hA9, 8'h81, 8'h00, acks);
        check_all("R5 R7 R8 alt");

        // R12 partial write keeps later bytes
        do_write(8'h12, 8'h03, 1, 8'h30, 8'h00, 8'h00, 8'h00, acks);
        check("R12 acks", 16'(acks), 16'd4);
        check_all("R12 partial");

        // R10 STOP in the middle of a data byte
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
        for (int i = 0; i < 4; i++) clock_bit(1'b1);
        bus_stop();
        check_all("R10 stop abort");

        // R10 repeated START switches to a read
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD3, a);
        check("R10 restart ack", {15'b0, a}, 16'd1);
        read_byte(1'b1, r0);
        check("R10 restart read byte0", {8'b0, r0}, {8'b0, view0()});
        // R9 R11 after NACK the slave stays off the line
        begin
            int held;
            held = 0;
            for (int i = 0; i < 9; i++) begin
                tick(Q); scl_m = 1'b1; tick(Q);
                if (sda_drive_low) held++;
                scl_m = 1'b0; tick(Q);
            end
            check("R9 R11 released after nack", 16'(held), 16'd0);
        end
        bus_stop();

        check("R11 no drive in master bits", 16'(drive_viol), 16'd0);
        check("R12 final outputs", {6'b0, outs_act()}, {6'b0, outs_exp()});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule